// File: doc/BRIEF.md
# Window-Decoded Instruction RAM

This block stands in the instruction-fetch path where an instruction cache would normally sit. It keeps the same fetch-side handshake: a request with an address goes in, and a ready strobe with an instruction word and a hit flag comes out. The fetch unit therefore needs no changes. There is no tag store. Every address inside one size-aligned window is served from an on-chip RAM with zero wait states. Every address outside the window goes to an external bus as a single-word read, and the fetch waits until that read completes.

The window base and the RAM size are parameters. Any power-of-two size works, from a few kilobytes up to half a megabyte or more, so the whole firmware image can sit in the RAM. A loader write port fills the RAM at boot, one 32-bit word at a time. The block assumes that no address translation takes place in front of it.

Top module: `ifetch_fixed_ram`

## Requirements
- R1: An address is inside the window exactly when its bits at and above log2(RAM_BYTES) equal those of BASE_ADDR. No other state affects the hit decision.
- R2: An accepted fetch inside the window raises fetch_rdy and fetch_hit in the next cycle. fetch_data in that cycle is the word stored at index fetch_addr[log2(RAM_BYTES)-1:2].
- R3: An accepted fetch outside the window leaves fetch_rdy low in the next cycle. In that same cycle bus_req is high and bus_addr equals the fetch address.
- R4: While a bus read is outstanding, bus_req stays high and bus_addr stays stable until bus_ack, and fetch_rdy stays low.
- R5: In the cycle after bus_ack, fetch_rdy is high, fetch_hit is low, fetch_data equals the bus_rdata sampled with the ack, and bus_req is low.
- R6: A loader write (ld_we high) to an address inside the window stores ld_data at index ld_addr[log2(RAM_BYTES)-1:2]. A later fetch of that address returns the new word.
- R7: A loader write to an address outside the window changes no RAM word, including the word its low bits would alias to.
- R8: A fetch request presented while a bus read is outstanding is ignored. It produces no ready strobe and does not alter bus_addr.
- R9: In the cycle after reset is applied, fetch_rdy and bus_req are low.
- R10: The last word of the window hits. The first word above the window and the last word below it both miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_rdy | output | 1 | Response strobe, one cycle per accepted fetch |
| fetch_hit | output | 1 | Response came from the on-chip RAM |
| fetch_data | output | 32 | Instruction word |
| bus_req | output | 1 | External single-word read request |
| bus_addr | output | 32 | External read address |
| bus_ack | input | 1 | External read completion |
| bus_rdata | input | 32 | External read data |
| ld_we | input | 1 | Loader write enable |
| ld_addr | input | 32 | Loader byte address |
| ld_data | input | 32 | Loader write word |

## Verification
The main fetch path is driven with addresses spread across the window, at both window edges, just below the base and far outside. This separates a correct range compare from one that checks too few or too many upper bits. Misses are answered after bus delays from zero to several cycles. This shows whether ready truly waits for the acknowledge and whether the bus address is held across the wait. Loader writes to an in-window word, and to an out-of-window address that aliases it, show whether writes are filtered by the window or only by the index bits. A second request issued while a miss is pending shows whether busy-time requests leak through as extra responses.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_BUS  = 1'b1
    } miss_state_e;

    typedef struct packed {
        logic valid;
        logic from_bus;
    } rsp_ctl_t;

    function automatic logic addr_in_window(word_t a, word_t base, int unsigned lg);
        return (a >> lg) == (base >> lg);
    endfunction

endpackage

// File: rtl/ifr_window.sv
module ifr_window
    import ifr_pkg::*;
#(
    parameter word_t       BASE_ADDR = 32'h0001_0000,
    parameter int unsigned SIZE_LOG2 = 12,
    parameter int unsigned NPORT     = 2
) (
    input  word_t addr_i [NPORT],
    output logic  in_win_o [NPORT]
);
    for (genvar p = 0; p < NPORT; p++) begin : g_cmp
        assign in_win_o[p] = addr_in_window(addr_i[p], BASE_ADDR, SIZE_LOG2);
    end
endmodule

// File: rtl/ifr_store.sv
module ifr_store
    import ifr_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2 = 10
) (
    input  logic                  clk,
    input  logic                  rd_en,
    input  logic [DEPTH_LOG2-1:0] rd_idx,
    output word_t                 rd_data,
    input  logic                  wr_en,
    input  logic [DEPTH_LOG2-1:0] wr_idx,
    input  word_t                 wr_data
);
    localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
        if (rd_en) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/ifr_miss.sv
module ifr_miss
    import ifr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t start_addr,
    input  logic  bus_ack,
    input  word_t bus_rdata,
    output logic  bus_req,
    output word_t bus_addr,
    output logic  busy,
    output logic  done,
    output word_t data_q
);
    miss_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= MS_IDLE;
            bus_addr <= '0;
            data_q   <= '0;
        end else begin
            case (state)
                MS_IDLE: if (start) begin
                    state    <= MS_BUS;
                    bus_addr <= start_addr;
                end
                MS_BUS: if (bus_ack) begin
                    state  <= MS_IDLE;
                    data_q <= bus_rdata;
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

    assign busy    = (state == MS_BUS);
    assign bus_req = busy;
    assign done    = busy && bus_ack;

    assert_bus_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));
endmodule

// File: rtl/ifetch_fixed_ram.sv
module ifetch_fixed_ram
    import ifr_pkg::*;
#(
    parameter word_t       BASE_ADDR = 32'h0001_0000,
    parameter int unsigned RAM_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_req,
    input  logic [31:0] fetch_addr,
    output logic        fetch_rdy,
    output logic        fetch_hit,
    output logic [31:0] fetch_data,
    output logic        bus_req,
    output logic [31:0] bus_addr,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    input  logic        ld_we,
    input  logic [31:0] ld_addr,
    input  logic [31:0] ld_data
);
    localparam int unsigned SIZE_LOG2  = $clog2(RAM_BYTES);
    localparam int unsigned DEPTH_LOG2 = SIZE_LOG2 - 2;

    word_t    win_addr [2];
    logic     win_hit  [2];
    logic     busy, miss_done, accept, hit_acc, miss_start;
    word_t    ram_q, miss_q;
    rsp_ctl_t ctl;

    assign win_addr[0] = fetch_addr;
    assign win_addr[1] = ld_addr;

    ifr_window #(.BASE_ADDR(BASE_ADDR), .SIZE_LOG2(SIZE_LOG2), .NPORT(2)) u_win (
        .addr_i   (win_addr),
        .in_win_o (win_hit)
    );

    assign accept     = fetch_req && !busy;
    assign hit_acc    = accept && win_hit[0];
    assign miss_start = accept && !win_hit[0];

    ifr_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_ram (
        .clk     (clk),
        .rd_en   (hit_acc),
        .rd_idx  (fetch_addr[SIZE_LOG2-1:2]),
        .rd_data (ram_q),
        .wr_en   (ld_we && win_hit[1]),
        .wr_idx  (ld_addr[SIZE_LOG2-1:2]),
        .wr_data (ld_data)
    );

    ifr_miss u_miss (
        .clk        (clk),
        .rst        (rst),
        .start      (miss_start),
        .start_addr (fetch_addr),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .busy       (busy),
        .done       (miss_done),
        .data_q     (miss_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            ctl.valid    <= hit_acc || miss_done;
            ctl.from_bus <= miss_done;
        end
    end

    assign fetch_rdy  = ctl.valid;
    assign fetch_hit  = ctl.valid && !ctl.from_bus;
    assign fetch_data = ctl.from_bus ? miss_q : ram_q;

    assert_hit_zero_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !bus_req && win_hit[0]) |=> (fetch_rdy && fetch_hit));

    assert_miss_issue_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !bus_req && !win_hit[0]) |=> (bus_req && !fetch_rdy && bus_addr == $past(fetch_addr)));

    assert_ack_return_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> (fetch_rdy && !fetch_hit && !bus_req && fetch_data == $past(bus_rdata)));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> !fetch_rdy);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!fetch_rdy && !bus_req));
endmodule

// File: tb/ifetch_fixed_ram_tb_top.sv
`timescale 1ns/1ps
module ifetch_fixed_ram_tb_top;

    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam int unsigned SIZE = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_rdy, fetch_hit;
    logic [31:0] fetch_data;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        ld_we = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_data = '0;

    int checks = 0;
    int fails  = 0;
    int bus_delay = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ifetch_fixed_ram #(.BASE_ADDR(BASE), .RAM_BYTES(SIZE)) dut_i (
        .clk(clk), .rst(rst),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rdy(fetch_rdy), .fetch_hit(fetch_hit), .fetch_data(fetch_data),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    function automatic logic [31:0] pat(logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic logic [31:0] ext(logic [31:0] a);
        return a ^ 32'h5A5A_5A5A;
    endfunction

    // External bus model: ack after bus_delay waiting cycles, data = ext(addr)
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                cnt = 0;
            end else if (bus_req) begin
                if (cnt == bus_delay) begin
                    bus_ack   = 1'b1;
                    bus_rdata = ext(bus_addr);
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic do_fetch(logic [31:0] a, logic exp_hit, logic [31:0] exp_data, string req);
        int n = 0;
        bit addr_bad = 0;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0;
        if (exp_hit) begin
            check({req, " R2 hit ready"}, {fetch_rdy, fetch_hit}, 2'b11);
            check({req, " R2 hit data"}, fetch_data, exp_data);
        end else begin
            check({req, " R3 miss issue"}, {fetch_rdy, bus_req}, 2'b01);
            check({req, " R3 bus addr"}, bus_addr, a);
            while (!fetch_rdy && n < 40) begin
                if (bus_req && bus_addr !== a) addr_bad = 1;
                @(negedge clk);
                n++;
            end
            check({req, " R4 wait cycles"}, n, bus_delay + 1);
            check({req, " R4 addr held"}, addr_bad, 0);
            check({req, " R5 return"}, {fetch_rdy, fetch_hit, bus_req}, 3'b100);
            check({req, " R5 data"}, fetch_data, exp_data);
        end
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [3:0]  delay;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{BASE + 32'h000, 1'b1, 4'd0},   // R1 window start
        '{BASE + 32'h004, 1'b1, 4'd0},
        '{BASE + 32'h01C, 1'b1, 4'd0},
        '{BASE + 32'hFFC, 1'b1, 4'd0},   // R10 last word in window
        '{BASE + 32'h1000, 1'b0, 4'd0},  // R10 first word above window
        '{BASE - 32'h4,   1'b0, 4'd2},   // R10 last word below window
        '{32'h0000_0000,  1'b0, 4'd1},   // R1 far below
        '{BASE + 32'h008, 1'b1, 4'd0},
        '{32'h8001_0004,  1'b0, 4'd5},   // R1 upper bit differs only
        '{BASE + 32'h010, 1'b1, 4'd0}
    };

    initial begin
        #800000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: outputs quiet after reset
        check("R9 reset state", {fetch_rdy, bus_req}, 2'b00);

        // R6 preload of window words
        for (int i = 0; i < 8; i++) load(BASE + 32'(4 * i), pat(BASE + 32'(4 * i)));
        load(BASE + 32'hFFC, pat(BASE + 32'hFFC));

        // Vector walk: R1, R2, R3, R4, R5, R10
        for (int v = 0; v < NVEC; v++) begin
            bus_delay = int'(VECS[v].delay);
            do_fetch(VECS[v].addr, VECS[v].hit,
                     VECS[v].hit ? pat(VECS[v].addr) : ext(VECS[v].addr), "R1 vec");
        end

        // R6: overwrite inside window, read back
        load(BASE + 32'h008, 32'hC0DE_0008);
        do_fetch(BASE + 32'h008, 1'b1, 32'hC0DE_0008, "R6 overwrite");

        // R7: write above window aliasing index 1 must not land
        load(BASE + 32'h1004, 32'hDEAD_BEEF);
        do_fetch(BASE + 32'h004, 1'b1, pat(BASE + 32'h004), "R7 alias untouched");
        load(BASE - 32'hFFC, 32'hDEAD_BEEF);
        do_fetch(BASE + 32'h004, 1'b1, pat(BASE + 32'h004), "R7 below untouched");

        // R8: requests during an outstanding miss are ignored
        begin
            int pulses = 0;
            logic [31:0] got = '0;
            bit addr_bad = 0;
            bus_delay = 5;
            @(negedge clk);
            fetch_req = 1'b1; fetch_addr = 32'h0002_0040;
            @(negedge clk);
            fetch_addr = BASE + 32'h00C;
            for (int k = 0; k < 14; k++) begin
                if (k == 3) fetch_req = 1'b0;
                if (bus_req && bus_addr !== 32'h0002_0040) addr_bad = 1;
                if (fetch_rdy) begin
                    pulses++;
                    got = fetch_data;
                end
                @(negedge clk);
            end
            fetch_req = 1'b0;
            check("R8 single response", pulses, 1);
            check("R8 response data", got, ext(32'h0002_0040));
            check("R8 bus addr stable", addr_bad, 0);
        end

        // R9: reset in mid-miss
        bus_delay = 8;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 32'h0003_0000;
        @(negedge clk);
        fetch_req = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset mid-miss", {fetch_rdy, bus_req}, 2'b00);
        rst = 1'b0;
        repeat (12) @(negedge clk);
        bus_delay = 0;
        do_fetch(BASE + 32'h01C, 1'b1, pat(BASE + 32'h01C), "R9 after reset");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule